// File: doc/BRIEF.md
# Packed Decimal Adder-Subtractor

This block does arithmetic on unsigned multi-digit decimal operands. Each operand is held as packed 4-bit digits. The logic is purely combinational. One control input picks between addition and subtraction. The digit count is a parameter and defaults to two. Each digit stage adds two digits in binary, then decides whether a decimal carry is due and adds six to bring the digit back into range. The carry then ripples on to the next stage.

Subtraction never uses a binary subtractor. Each digit of the second operand is replaced by its nines complement, which is the digit inverted plus ten with the top carry dropped, and the result is added to the first operand. A carry out of the top digit means the difference is positive; that carry is fed back into the lowest digit through a second correcting pass. If there is no top carry, the difference is negative: the magnitude is the nines complement of the intermediate sum and the sign output is raised. Equal operands give a plain zero.

Top module: `bcd_addsub`

## Requirements
- R1: Digit i of every operand and of the result sits at bits [4i+3:4i], with digit 0 least significant, coded with weights 8-4-2-1. Only 0000 to 1001 are legal digit codes.
- R2: With subMode=0, result equals (A+B) mod 10^DIGITS, sign is 0, and carryOut is 1 exactly when A+B is at least 10^DIGITS.
- R3: A digit sum above nine carries into the next digit, and the carry can ripple through several digits. For example, 99+01 gives result 00 with carryOut=1, and 09+09 gives 18.
- R4: With subMode=1 and A>B, result is A-B and sign is 0. Required cases: 08-03=05, 87-39=48, 65-12=53, 54-21=33.
- R5: With subMode=1 and A<B, result is the magnitude B-A and sign is 1. Required cases: 03-08 gives 05 with sign 1, and 18-72 gives 54 with sign 1.
- R6: With subMode=1 and A=B, result is zero and sign is 0 (no negative zero).
- R7: With subMode=1, carryOut is always 0.
- R8: invalid is 1 when any digit of A or B is above 1001, and 0 otherwise. While invalid is 1, the other outputs carry no meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4*DIGITS | First operand, packed decimal digits |
| opB | input | 4*DIGITS | Second operand, packed decimal digits |
| subMode | input | 1 | 0 selects A+B, 1 selects A-B |
| result | output | 4*DIGITS | Sum, or magnitude of the difference |
| sign | output | 1 | 1 when the difference is negative |
| carryOut | output | 1 | Decimal carry out of the top digit, add mode only |
| invalid | output | 1 | Some input digit holds an illegal code |

## Verification
Every pair of two-digit operands is applied in both modes. This sweep separates the no-carry sums, the sums that overflow the top digit, and the three outcomes of subtraction: end-around carry, recomplement, and equality. Named cases cover the required differences and the carry that ripples through nines. Other cases put an illegal code in each operand and in each digit position, against legal borderline nines, to show that only the flag is driven by digit legality.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;

  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] digit_t;

  // operand-path strobe: choose true or nines-complement second operand
  typedef struct packed {
    logic cplB;
  } op_sel_t;

  // result-path strobes chosen after the first pass carry is known
  typedef struct packed {
    logic endAround;
    logic recomp;
  } fix_sel_t;

  // one decimal digit stage: binary add, then +6 when the decimal carry is due
  function automatic logic [DIGIT_W:0] digitAdd(digit_t a, digit_t b, logic cin);
    logic [DIGIT_W:0] raw;
    logic             decCarry;
    digit_t           adj;
    raw      = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    decCarry = raw[4] | (raw[3] & raw[2]) | (raw[3] & raw[1]);
    adj      = raw[3:0] + (decCarry ? 4'b0110 : 4'b0000);
    return {decCarry, adj};
  endfunction

  // nines complement: invert and add ten, top carry dropped
  function automatic digit_t ninesOf(digit_t d);
    digit_t inv;
    inv = ~d;
    return inv + 4'b1010;
  endfunction

  function automatic logic digitIllegal(digit_t d);
    return d > 4'd9;
  endfunction

endpackage

// File: rtl/bcd_addsub_ctrl.sv
module bcd_addsub_ctrl
  import bcd_addsub_pkg::*;
(
  input  logic     subMode,
  input  logic     firstCarry,
  input  logic     magZero,
  output op_sel_t  opSel,
  output fix_sel_t fixSel,
  output logic     sign,
  output logic     carryOut
);

  always_comb begin
    opSel.cplB       = subMode;
    fixSel.endAround = subMode & firstCarry;
    fixSel.recomp    = subMode & ~firstCarry;
    // a recomplemented all-nines sum is zero; keep it positive
    sign             = subMode & ~firstCarry & ~magZero;
    carryOut         = ~subMode & firstCarry;
  end

  // exactly one of end-around and recomplement in subtract mode, neither in add mode
  always_comb begin
    a_r4_fix_exclusive: assert (subMode ? $countones({fixSel.endAround, fixSel.recomp}) == 1
                                        : {fixSel.endAround, fixSel.recomp} == 2'b00)
      else $error("fix strobes inconsistent with mode");
  end

endmodule

// File: rtl/bcd_addsub_datapath.sv
module bcd_addsub_datapath
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int WIDTH = DIGITS * DIGIT_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  op_sel_t          opSel,
  input  fix_sel_t         fixSel,
  output logic             firstCarry,
  output logic [WIDTH-1:0] magnitude,
  output logic             magZero,
  output logic             digitBad
);

  logic [WIDTH-1:0] bPath;
  logic [WIDTH-1:0] firstSum;
  logic [WIDTH-1:0] secondSum;
  logic [WIDTH-1:0] recompSum;

  // operand conditioning: per-digit true / nines-complement select
  always_comb begin
    for (int i = 0; i < DIGITS; i++) begin
      bPath[i*DIGIT_W +: DIGIT_W] = opSel.cplB ? ninesOf(opB[i*DIGIT_W +: DIGIT_W])
                                               : opB[i*DIGIT_W +: DIGIT_W];
    end
  end

  // first pass: A plus conditioned B, ripple through digit stages
  always_comb begin
    logic             c;
    logic [DIGIT_W:0] r;
    c        = 1'b0;
    r        = '0;
    firstSum = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r = digitAdd(opA[i*DIGIT_W +: DIGIT_W], bPath[i*DIGIT_W +: DIGIT_W], c);
      firstSum[i*DIGIT_W +: DIGIT_W] = r[DIGIT_W-1:0];
      c = r[DIGIT_W];
    end
    firstCarry = c;
  end

  // second pass: fold the end-around carry into the lowest digit
  always_comb begin
    logic             c;
    logic [DIGIT_W:0] r;
    c         = fixSel.endAround;
    r         = '0;
    secondSum = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r = digitAdd(firstSum[i*DIGIT_W +: DIGIT_W], '0, c);
      secondSum[i*DIGIT_W +: DIGIT_W] = r[DIGIT_W-1:0];
      c = r[DIGIT_W];
    end
  end

  // recomplement path for a negative difference
  always_comb begin
    for (int i = 0; i < DIGITS; i++) begin
      recompSum[i*DIGIT_W +: DIGIT_W] = ninesOf(firstSum[i*DIGIT_W +: DIGIT_W]);
    end
  end

  always_comb begin
    magnitude = fixSel.recomp ? recompSum : secondSum;
    magZero   = (magnitude == '0);
  end

  always_comb begin
    digitBad = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      digitBad = digitBad | digitIllegal(opA[i*DIGIT_W +: DIGIT_W])
                          | digitIllegal(opB[i*DIGIT_W +: DIGIT_W]);
    end
  end

  // legal operands give legal digits on every pass and on the output
  always_comb begin
    if (!digitBad) begin
      for (int i = 0; i < DIGITS; i++) begin
        a_r1_first_legal: assert (firstSum[i*DIGIT_W +: DIGIT_W] <= 4'd9)
          else $error("first pass digit %0d illegal", i);
        a_r1_result_legal: assert (magnitude[i*DIGIT_W +: DIGIT_W] <= 4'd9)
          else $error("result digit %0d illegal", i);
        a_r5_nines_pair: assert (!opSel.cplB ||
            ({1'b0, bPath[i*DIGIT_W +: DIGIT_W]} + {1'b0, opB[i*DIGIT_W +: DIGIT_W]} == 5'd9))
          else $error("nines complement of digit %0d wrong", i);
      end
    end
  end

endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int WIDTH = DIGITS * DIGIT_W
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] result,
  output logic             sign,
  output logic             carryOut,
  output logic             invalid
);

  op_sel_t  opSel;
  fix_sel_t fixSel;
  logic     firstCarry;
  logic     magZero;

  bcd_addsub_ctrl ctrl_i (
    .subMode    (subMode),
    .firstCarry (firstCarry),
    .magZero    (magZero),
    .opSel      (opSel),
    .fixSel     (fixSel),
    .sign       (sign),
    .carryOut   (carryOut)
  );

  bcd_addsub_datapath #(.DIGITS(DIGITS)) dp_i (
    .opA        (opA),
    .opB        (opB),
    .opSel      (opSel),
    .fixSel     (fixSel),
    .firstCarry (firstCarry),
    .magnitude  (result),
    .magZero    (magZero),
    .digitBad   (invalid)
  );

  always_comb begin
    if (!invalid) begin
      a_r6_no_neg_zero: assert (!sign || result != '0)
        else $error("negative zero on output");
      a_r2_add_positive: assert (subMode || !sign)
        else $error("sign raised in add mode");
      a_r7_sub_no_carry: assert (!subMode || !carryOut)
        else $error("carry raised in subtract mode");
    end
  end

endmodule

// File: tb/bcd_addsub_tb_top.sv
`timescale 1ns/1ps
module bcd_addsub_tb_top;

  localparam int DIGITS = 2;
  localparam int WIDTH  = DIGITS * 4;
  localparam int LIMIT  = 100; // 10^DIGITS

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic             subMode = 1'b0;
  logic [WIDTH-1:0] result;
  logic             sign;
  logic             carryOut;
  logic             invalid;

  always #4 clk = ~clk;

  bcd_addsub #(.DIGITS(DIGITS)) dut_i (
    .opA      (opA),
    .opB      (opB),
    .subMode  (subMode),
    .result   (result),
    .sign     (sign),
    .carryOut (carryOut),
    .invalid  (invalid)
  );

  typedef struct packed {
    logic [WIDTH-1:0] res;
    logic             sgn;
    logic             cy;
    logic             bad;
    logic             flagOnly;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    checkCnt = 0;
  int    failCnt  = 0;
  bit    done     = 0;

  function automatic logic [WIDTH-1:0] toBcd(int v);
    logic [WIDTH-1:0] r;
    r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int fromBcd(logic [WIDTH-1:0] b);
    int v;
    v = 0;
    for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + int'(b[i*4 +: 4]);
    return v;
  endfunction

  // driver: apply operands and push the expected outcome
  task automatic drive(int a, int b, logic sub, string tag);
    exp_t e;
    int   d;
    @(posedge clk);
    opA     = toBcd(a);
    opB     = toBcd(b);
    subMode = sub;
    e = '0;
    if (!sub) begin
      e.res = toBcd((a + b) % LIMIT);
      e.cy  = (a + b) >= LIMIT;
    end else begin
      d     = a - b;
      e.sgn = d < 0;
      e.res = toBcd(d < 0 ? -d : d);
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // driver for raw codes, checking only the legality flag
  task automatic driveRaw(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic sub,
                          logic expBad, string tag);
    exp_t e;
    @(posedge clk);
    opA     = a;
    opB     = b;
    subMode = sub;
    e = '0;
    e.bad      = expBad;
    e.flagOnly = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor: compare at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkCnt++;
        if (e.flagOnly) begin
          if (invalid !== e.bad) begin
            failCnt++;
            $display("FAIL %s invalid actual=%0b expected=%0b (A=%h B=%h)",
                     t, invalid, e.bad, opA, opB);
          end
        end else if (result !== e.res || sign !== e.sgn || carryOut !== e.cy || invalid !== 1'b0) begin
          failCnt++;
          $display("FAIL %s A=%h B=%h sub=%0b actual res=%h sgn=%0b cy=%0b bad=%0b expected res=%h sgn=%0b cy=%0b bad=0",
                   t, opA, opB, subMode, result, sign, carryOut, invalid, e.res, e.sgn, e.cy);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: zero operands in add mode give all-zero outputs (R2)
    drive(0, 0, 1'b0, "R2 reset-state");
    // field positions (R1)
    drive(4, 30, 1'b0, "R1 digit-order");
    drive(90, 9, 1'b0, "R1 digit-order");
    // ripple carries (R3)
    drive(99, 1, 1'b0, "R3 ripple");
    drive(9, 9, 1'b0, "R3 digit-carry");
    drive(99, 99, 1'b0, "R3 max-sum");
    // required differences
    drive(8, 3, 1'b1, "R4 8-3");
    drive(87, 39, 1'b1, "R4 87-39");
    drive(65, 12, 1'b1, "R4 65-12");
    drive(54, 21, 1'b1, "R4 54-21");
    drive(3, 8, 1'b1, "R5 3-8");
    drive(18, 72, 1'b1, "R5 18-72");
    // equality (R6) and no carry in subtract (R7)
    drive(47, 47, 1'b1, "R6 equal");
    drive(0, 0, 1'b1, "R6 zero");
    drive(99, 0, 1'b1, "R7 max-minus-zero");
    drive(0, 99, 1'b1, "R7 zero-minus-max");
    // legality flag (R8)
    driveRaw(8'h0A, 8'h00, 1'b0, 1'b1, "R8 A-low-illegal");
    driveRaw(8'h00, 8'hF0, 1'b1, 1'b1, "R8 B-high-illegal");
    driveRaw(8'hB0, 8'h05, 1'b1, 1'b1, "R8 A-high-illegal");
    driveRaw(8'h99, 8'h99, 1'b1, 1'b0, "R8 nines-legal");
    driveRaw(8'h55, 8'h0C, 1'b0, 1'b1, "R8 B-low-illegal");
    // full sweep of both modes
    for (int a = 0; a < LIMIT; a++) begin
      for (int b = 0; b < LIMIT; b++) begin
        drive(a, b, 1'b0, (a + b >= LIMIT) ? "R3 sweep-add-carry" : "R2 sweep-add");
        drive(a, b, 1'b1, (a > b) ? "R4 sweep-sub" : ((a < b) ? "R5 sweep-sub" : "R6 sweep-sub"));
      end
    end
    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule